// File: doc/BRIEF.md
# External-Trigger Clocked Timer Counter

This block is a 16-bit up-counter that takes its count enable from one of two sources. In internal mode it advances on every cycle of the system clock. In external mode it advances once for each qualified edge on an asynchronous trigger pin. In that mode the pin passes through a polarity inverter, a two-flop synchroniser and an edge-group prescaler. An optional majority-free digital filter comes next, and the result is a single-cycle enable aligned to the system clock.

Configuration arrives as static fields driven by a surrounding register file. These fields select the polarity, the prescale ratio, the filter length, the clock source and the run enable. The counter value is the only output. Dropping the external-mode enable clears the prescaler and the filter, so a new run always starts with a fresh edge group.

Top module: `ext_tick_counter`

## Requirements
- R1: While `rst` is high at a clock edge, `count` becomes 0.
- R2: When `cfg_run` is 0, `count` holds its value in both modes.
- R3: With `cfg_run`=1 and `cfg_ext_en`=0, `count` increases by one on every rising clock edge.
- R4: `count` wraps from 16'hFFFF to 16'h0000.
- R5: With `cfg_ext_en`=1, `cfg_invert`=0, `cfg_div`=00 and `cfg_filt`=0000, each rising pin edge adds one to `count`, and the increment appears at the fifth rising clock edge after the pin changes.
- R6: With `cfg_invert`=1, falling pin edges are counted instead of rising ones.
- R7: `cfg_div` encodes the edge ratio: 00 = every edge, 01 = one in 2, 10 = one in 4, 11 = one in 8. The first edge after external mode is enabled is always counted.
- R8: `cfg_filt`=0000 disables the filter. A nonzero code sets a length N = 2*(cfg_filt[3:2]+1), and the filtered level changes only after N consecutive differing samples. A trigger pulse shorter than N cycles is dropped, and an accepted edge arrives N-1 cycles later than with the filter off.
- R9: Driving `cfg_ext_en` low clears the prescaler group position, so the next edge after re-enabling is counted.
- R10: In external mode, a pin that does not toggle leaves `count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_pin | input | 1 | Asynchronous external trigger |
| cfg_invert | input | 1 | 0 counts rising edges, 1 counts falling edges |
| cfg_div | input | 2 | Edge prescale code |
| cfg_filt | input | 4 | Filter length code |
| cfg_ext_en | input | 1 | 1 selects the trigger as the count source |
| cfg_run | input | 1 | Counter enable |
| count | output | 16 | Counter value |

## Verification
A stale prescaler group position shows up at the ports within one group of edges: after a mode toggle, the first pulse fails to add one. A filter run length that is off by one either lets a pulse through that should be dropped or shifts the increment by a cycle. The bench therefore samples the count at the exact cycle the pipeline delay predicts. A synchroniser with the wrong depth moves the fifth-edge increment and is caught by the latency check. Wrap and internal counting errors appear on the first affected edge.

// File: rtl/ext_tick_pkg.sv
package ext_tick_pkg;

    localparam int CNT_W   = 16;
    localparam int SYNC_N  = 2;
    localparam int GROUP_W = 3;
    localparam int FILT_W  = 4;

    typedef enum logic [1:0] {
        DIV_1 = 2'b00,
        DIV_2 = 2'b01,
        DIV_4 = 2'b10,
        DIV_8 = 2'b11
    } div_e;

    // Last group index for a prescale code (ratio minus one)
    function automatic logic [GROUP_W-1:0] group_last(div_e d);
        case (d)
            DIV_1:   return GROUP_W'(0);
            DIV_2:   return GROUP_W'(1);
            DIV_4:   return GROUP_W'(3);
            default: return GROUP_W'(7);
        endcase
    endfunction

    // Consecutive-sample run length; zero means bypass
    function automatic logic [FILT_W-1:0] filt_len(logic [3:0] code);
        if (code == 4'd0) return '0;
        return FILT_W'({2'b00, code[3:2]} + 4'd1) << 1;
    endfunction

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
    parameter int STAGES = ext_tick_pkg::SYNC_N
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic invert,
    output logic lvl
);
    logic [STAGES-1:0] sh;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= pin ^ invert;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= {sh[STAGES-2:0], pin ^ invert};
            end
        end
    endgenerate

    assign lvl = sh[STAGES-1];
endmodule

// File: rtl/trig_prescaler.sv
module trig_prescaler
    import ext_tick_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic lvl,
    input  div_e div,
    output logic pre_lvl
);
    logic               prev;
    logic               sel;
    logic [GROUP_W-1:0] grp;
    logic               rise;

    assign rise = lvl & ~prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= 1'b0;
            sel  <= 1'b0;
            grp  <= '0;
        end else begin
            prev <= lvl;
            if (clr) begin
                sel <= 1'b0;
                grp <= '0;
            end else if (rise) begin
                sel <= (grp == '0);
                grp <= (grp >= group_last(div)) ? '0 : grp + GROUP_W'(1);
            end
        end
    end

    assign pre_lvl = prev & sel;

    // R7
    pre_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && $rose(pre_lvl) |-> $past(lvl) && !$past(prev));

    // R9
    pre_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && $past(clr) |-> !pre_lvl);
endmodule

// File: rtl/trig_filter.sv
module trig_filter
    import ext_tick_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       in_lvl,
    input  logic [3:0] code,
    output logic       out_lvl
);
    logic [FILT_W-1:0] len;
    logic [FILT_W-1:0] run_c;

    assign len = filt_len(code);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            out_lvl <= 1'b0;
            run_c   <= '0;
        end else if (len == '0) begin
            out_lvl <= in_lvl;
            run_c   <= '0;
        end else if (in_lvl == out_lvl) begin
            run_c <= '0;
        end else if (run_c == len - FILT_W'(1)) begin
            out_lvl <= in_lvl;
            run_c   <= '0;
        end else begin
            run_c <= run_c + FILT_W'(1);
        end
    end

    // R8
    filt_follow_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && $past(!clr) && (out_lvl != $past(out_lvl)) |-> $past(in_lvl) == out_lvl);

    // R8
    filt_min_run_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst, 2) && $past(!clr, 2) && $past(len) != '0 && $stable(code)
        && $rose(out_lvl) |-> $past(in_lvl, 2));
endmodule

// File: rtl/trig_counter.sv
module trig_counter #(
    parameter int W = ext_tick_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         ext_en,
    input  logic         filt_lvl,
    output logic [W-1:0] count
);
    logic fprev;
    logic tick;

    assign tick = filt_lvl & ~fprev;

    always_ff @(posedge clk) begin
        if (rst) begin
            fprev <= 1'b0;
            count <= '0;
        end else begin
            fprev <= ext_en ? filt_lvl : 1'b0;
            if (run && (!ext_en || tick))
                count <= count + W'(1);
        end
    end

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && !$past(run) |-> $stable(count));

    // R3
    internal_step_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && $past(run) && !$past(ext_en) |-> count == $past(count) + W'(1));

    // R5
    ext_single_step_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && $past(ext_en) |-> (count == $past(count)) || (count == $past(count) + W'(1)));

    // R4
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && $past(count) == {W{1'b1}} && !$stable(count) |-> count == '0);
endmodule

// File: rtl/ext_tick_counter.sv
module ext_tick_counter
    import ext_tick_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_pin,
    input  logic             cfg_invert,
    input  logic [1:0]       cfg_div,
    input  logic [3:0]       cfg_filt,
    input  logic             cfg_ext_en,
    input  logic             cfg_run,
    output logic [CNT_W-1:0] count
);
    logic sync_lvl;
    logic pre_lvl;
    logic filt_lvl;
    logic clr;

    assign clr = ~cfg_ext_en;

    trig_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst(rst), .pin(trig_pin), .invert(cfg_invert), .lvl(sync_lvl)
    );

    trig_prescaler u_pre (
        .clk(clk), .rst(rst), .clr(clr), .lvl(sync_lvl),
        .div(div_e'(cfg_div)), .pre_lvl(pre_lvl)
    );

    trig_filter u_filt (
        .clk(clk), .rst(rst), .clr(clr), .in_lvl(pre_lvl),
        .code(cfg_filt), .out_lvl(filt_lvl)
    );

    trig_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .run(cfg_run), .ext_en(cfg_ext_en),
        .filt_lvl(filt_lvl), .count(count)
    );

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        $past(rst) |-> count == '0);
endmodule

// File: tb/ext_tick_counter_bench.sv
module ext_tick_counter_bench;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst;
    logic        trig_pin;
    logic        cfg_invert;
    logic [1:0]  cfg_div;
    logic [3:0]  cfg_filt;
    logic        cfg_ext_en;
    logic        cfg_run;
    logic [15:0] count;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [15:0] model;

    typedef struct {
        logic [15:0] val;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_tick_counter u_ext_tick_counter (
        .clk(clk), .rst(rst), .trig_pin(trig_pin), .cfg_invert(cfg_invert),
        .cfg_div(cfg_div), .cfg_filt(cfg_filt), .cfg_ext_en(cfg_ext_en),
        .cfg_run(cfg_run), .count(count)
    );

    // Driver side: push an expectation into the scoreboard
    task automatic expect_val(input logic [15:0] v, input string tag);
        exp_t e;
        e.val = v;
        e.tag = tag;
        sb.push_back(e);
        #0;
    endtask

    // Monitor: pops and compares while outputs are stable
    initial begin
        forever begin
            wait (sb.size() != 0);
            begin
                exp_t it;
                it = sb.pop_front();
                checks++;
                if (count !== it.val) begin
                    errors++;
                    $display("FAIL %s: count=%h expected=%h", it.tag, count, it.val);
                end
            end
        end
    end

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup_ext(input logic inv, input logic [1:0] dv, input logic [3:0] fl);
        @(negedge clk);
        cfg_run    = 1'b0;
        cfg_ext_en = 1'b0;
        cfg_invert = inv;
        cfg_div    = dv;
        cfg_filt   = fl;
        trig_pin   = inv;
        ticks(4);
        cfg_ext_en = 1'b1;
        cfg_run    = 1'b1;
        ticks(2);
    endtask

    task automatic pulse(input int hi, input int lo);
        trig_pin = ~cfg_invert;
        ticks(hi);
        trig_pin = cfg_invert;
        ticks(lo);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) pulse(6, 14);
    endtask

    initial begin
        rst = 1'b1; trig_pin = 1'b0; cfg_invert = 1'b0; cfg_div = 2'b00;
        cfg_filt = 4'd0; cfg_ext_en = 1'b0; cfg_run = 1'b0;
        model = 16'd0;
        ticks(3);
        expect_val(16'd0, "R1 reset value");
        rst = 1'b0;
        ticks(3);
        expect_val(16'd0, "R2 idle after reset");

        // Internal counting
        cfg_run = 1'b1;
        ticks(10);
        model += 16'd10;
        expect_val(model, "R3 internal ten cycles");
        cfg_run = 1'b0;
        ticks(6);
        expect_val(model, "R2 hold with run low");

        // External, rising, no prescale
        setup_ext(1'b0, 2'b00, 4'd0);
        ticks(20);
        expect_val(model, "R10 idle pin no count");
        pulses(5);
        model += 16'd5;
        expect_val(model, "R5 five rising edges");

        // Latency: increment at fifth edge
        trig_pin = 1'b1;
        ticks(4);
        expect_val(model, "R5 not yet after four edges");
        ticks(1);
        model += 16'd1;
        expect_val(model, "R5 counted at fifth edge");
        ticks(3);
        trig_pin = 1'b0;
        ticks(14);

        // Falling polarity
        setup_ext(1'b1, 2'b00, 4'd0);
        pulses(4);
        model += 16'd4;
        expect_val(model, "R6 falling edges counted");

        // Prescale ratios
        setup_ext(1'b0, 2'b01, 4'd0);
        pulses(6);
        model += 16'd3;
        expect_val(model, "R7 divide by 2");
        setup_ext(1'b0, 2'b10, 4'd0);
        pulses(8);
        model += 16'd2;
        expect_val(model, "R7 divide by 4");
        setup_ext(1'b0, 2'b11, 4'd0);
        pulses(9);
        model += 16'd2;
        expect_val(model, "R7 divide by 8 first edge counts");

        // Phase cleared by disabling external mode
        setup_ext(1'b0, 2'b10, 4'd0);
        pulses(2);
        model += 16'd1;
        expect_val(model, "R9 first group");
        @(negedge clk);
        cfg_ext_en = 1'b0;
        cfg_run = 1'b0;
        ticks(2);
        cfg_ext_en = 1'b1;
        cfg_run = 1'b1;
        ticks(2);
        pulses(1);
        model += 16'd1;
        expect_val(model, "R9 restart counts first edge");

        // Filter
        setup_ext(1'b0, 2'b00, 4'd1);
        pulse(1, 14);
        expect_val(model, "R8 one cycle glitch dropped N=2");
        pulse(6, 14);
        model += 16'd1;
        expect_val(model, "R8 long pulse passes N=2");
        setup_ext(1'b0, 2'b00, 4'd4);
        pulse(3, 14);
        expect_val(model, "R8 three cycle glitch dropped N=4");
        trig_pin = 1'b1;
        ticks(7);
        expect_val(model, "R8 N=4 not yet at edge seven");
        ticks(1);
        model += 16'd1;
        expect_val(model, "R8 N=4 counted at edge eight");
        ticks(2);
        trig_pin = 1'b0;
        ticks(16);
        setup_ext(1'b0, 2'b00, 4'd0);
        pulse(1, 14);
        model += 16'd1;
        expect_val(model, "R8 filter off passes short pulse");

        // Wrap through internal counting
        @(negedge clk);
        cfg_ext_en = 1'b0;
        cfg_run = 1'b1;
        ticks(16'hFFFF - model);
        expect_val(16'hFFFF, "R4 reached all ones");
        ticks(1);
        expect_val(16'h0000, "R4 wrapped to zero");
        ticks(1);
        expect_val(16'h0001, "R3 continues after wrap");

        ticks(2);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule